// File: doc/BRIEF.md
# Receive Source Select and Clock-Recovery Reacquisition Control

This block is the digital control around a serial receiver's clock-recovery loop. It picks the bit stream to pass downstream, either the line input or the internal loopback stream, and registers it once in the reference-clock domain. It also decides whether the recovery loop may follow the incoming data or must be pulled back onto the local reference clock. Loss of optical signal, reset and a data line that stays idle for a long time all pull the loop back to the reference.

The loop returns to data tracking only after the loop's raw lock indication has been held for a set number of consecutive reference cycles, with nothing left requesting the reference. The reported lock detect is the raw lock qualified by that tracking state and by the absence of signal loss. A separate test-clock enable drives the clock-source select, so that the reference clock can stand in for the oscillator. The mode inputs are brought into the reference domain through a synchronizer chain of a depth set by a parameter. The idle-line window is a parameter given in reference cycles. Its default equals 16 ms at 100 MHz.

Top module: `rx_source_reacq`

## Requirements
- R1: With `use_primary` high, `data_out` carries `pri_bit`. With it low, `data_out` carries `lpbk_bit`. The chosen bit appears one clock after it is sampled. A change of `use_primary` takes effect on the third rising edge after it changes: two synchronizer stages, then the data register.
- R2: While loss of signal is high and the primary input is selected, `data_out` is 0 from the third rising edge after `los_in` rises.
- R3: While the synchronized loss of signal is high, `lock_det` is low. This holds from the second rising edge after `los_in` rises.
- R4: Loss of signal sets `ref_lock_cmd` to 1 (lock to reference) from the third rising edge after `los_in` rises.
- R5: While `rst_n` is low, `ref_lock_cmd` is 1 and `lock_det`, `data_out` and `clk_src_sel` are 0, without waiting for a clock edge.
- R6: Suppose the selected, conditioned data shows no change for QUIET_CYCLES consecutive rising edges after the edge that registered its last change. Then `ref_lock_cmd` rises on the next edge. A new transition clears the idle condition.
- R7: When nothing requests the reference, `ref_lock_cmd` falls on the LOCK_CYCLES-th consecutive rising edge at which `raw_lock` is high. Any edge with `raw_lock` low restarts the count.
- R8: While data is being tracked (`ref_lock_cmd` = 0), `lock_det` follows `raw_lock`. A drop of `raw_lock` alone does not raise `ref_lock_cmd`.
- R9: `clk_src_sel` (1 = reference clock replaces the oscillator) follows `test_clk_en` two rising edges later.
- R10: Loss of signal has no effect on the loopback data. With `use_primary` low, `data_out` still carries `lpbk_bit` while loss of signal is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_bit | input | 1 | Line serial data bit |
| lpbk_bit | input | 1 | Loopback serial data bit |
| use_primary | input | 1 | 1 selects the line input, 0 selects the loopback input (asynchronous) |
| los_in | input | 1 | Loss of signal, active high (asynchronous) |
| test_clk_en | input | 1 | Test clock enable (asynchronous) |
| raw_lock | input | 1 | Raw lock indication from the recovery loop |
| data_out | output | 1 | Conditioned, registered data bit |
| ref_lock_cmd | output | 1 | 1 commands the loop to lock to the reference |
| lock_det | output | 1 | Qualified lock detect |
| clk_src_sel | output | 1 | 1 selects the reference clock in place of the oscillator |

## Verification
The hardest case to reach is the idle-line timeout with an exact edge count. The idle counter keeps running between scenarios, so its phase at any moment is unknown. The bench first stops toggling and lets one edge pass. It then flips the line bit itself, which creates a single transition that is known to clear the counter. From there it counts QUIET_CYCLES+1 edges with the reference command still low, and the next edge raises it. The relock restart test reaches its state by first forcing the reference with a loss-of-signal pulse and then holding `raw_lock` low, so the lock count starts from zero.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic {
      ACQ_REF    = 1'b0,
      TRACK_DATA = 1'b1
   } acq_state_e;
endpackage

// File: rtl/rxr_sync.sv
module rxr_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rxr_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("rxr_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rxr_quiet_timer.sv
module rxr_quiet_timer #(
   parameter int QUIET_CYCLES = 1_600_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic toggle,
   output logic quiet
);
   localparam int QW = $clog2(QUIET_CYCLES + 1);
   localparam logic [QW-1:0] QLIM = QW'(QUIET_CYCLES);

   if (QUIET_CYCLES < 2) begin : g_bad_quiet
      $error("rxr_quiet_timer: QUIET_CYCLES must be at least 2");
   end

   logic [QW-1:0] idle_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  idle_cnt_q <= '0;
      else if (toggle)             idle_cnt_q <= '0;
      else if (idle_cnt_q != QLIM) idle_cnt_q <= idle_cnt_q + 1'b1;
   end

   assign quiet = (idle_cnt_q == QLIM);

   // R6
   quiet_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |-> !$past(toggle));
endmodule

// File: rtl/rxr_acq_fsm.sv
module rxr_acq_fsm
   import rxr_pkg::*;
#(
   parameter int LOCK_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_req,
   input  logic los_s,
   input  logic raw_lock,
   output logic ref_cmd,
   output logic lock_det
);
   localparam int LW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
   localparam logic [LW-1:0] LLAST = LW'(LOCK_CYCLES - 1);

   if (LOCK_CYCLES < 1) begin : g_bad_lock
      $error("rxr_acq_fsm: LOCK_CYCLES must be at least 1");
   end

   acq_state_e    state_q;
   logic [LW-1:0] lock_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ACQ_REF;
         lock_cnt_q <= '0;
      end else begin
         case (state_q)
            ACQ_REF: begin
               if (ref_req || !raw_lock) begin
                  lock_cnt_q <= '0;
               end else if (lock_cnt_q == LLAST) begin
                  lock_cnt_q <= '0;
                  state_q    <= TRACK_DATA;
               end else begin
                  lock_cnt_q <= lock_cnt_q + 1'b1;
               end
            end
            default: begin
               lock_cnt_q <= '0;
               if (ref_req) state_q <= ACQ_REF;
            end
         endcase
      end
   end

   assign ref_cmd  = (state_q == ACQ_REF);
   assign lock_det = (state_q == TRACK_DATA) && raw_lock && !los_s;

   // R4
   los_forces_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      los_s |=> ref_cmd);

   // R7
   release_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ref_cmd) |-> $past(raw_lock));
endmodule

// File: rtl/rx_source_reacq.sv
module rx_source_reacq #(
   parameter int SYNC_STAGES  = 2,
   parameter int QUIET_CYCLES = 1_600_000,
   parameter int LOCK_CYCLES  = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pri_bit,
   input  logic lpbk_bit,
   input  logic use_primary,
   input  logic los_in,
   input  logic test_clk_en,
   input  logic raw_lock,
   output logic data_out,
   output logic ref_lock_cmd,
   output logic lock_det,
   output logic clk_src_sel
);
   localparam int NCTL = 3;

   logic [NCTL-1:0] ctl_s;
   logic            sel_s, los_s;
   logic            cond_d, data_q;
   logic            toggle, quiet, ref_req;

   rxr_sync #(.WIDTH(NCTL), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({test_clk_en, los_in, use_primary}),
      .q     (ctl_s)
   );

   assign sel_s       = ctl_s[0];
   assign los_s       = ctl_s[1];
   assign clk_src_sel = ctl_s[2];

   assign cond_d = sel_s ? (pri_bit & ~los_s) : lpbk_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q <= 1'b0;
      else        data_q <= cond_d;
   end

   assign data_out = data_q;
   assign toggle   = cond_d ^ data_q;

   rxr_quiet_timer #(.QUIET_CYCLES(QUIET_CYCLES)) u_quiet (
      .clk    (clk),
      .rst_n  (rst_n),
      .toggle (toggle),
      .quiet  (quiet)
   );

   assign ref_req = los_s | quiet;

   rxr_acq_fsm #(.LOCK_CYCLES(LOCK_CYCLES)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_req  (ref_req),
      .los_s    (los_s),
      .raw_lock (raw_lock),
      .ref_cmd  (ref_lock_cmd),
      .lock_det (lock_det)
   );

   // R2
   los_zeroes_primary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_s && los_s) |=> !data_out);

   // R10
   loopback_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_s |=> (data_out == $past(lpbk_bit)));

   // R3
   los_blocks_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      los_s |-> !lock_det);
endmodule

// File: tb/tb_rx_source_reacq.sv
module tb_rx_source_reacq;
   localparam int QUIET = 40;
   localparam int LOCK  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pri_bit = 1'b0, lpbk_bit = 1'b0, use_primary = 1'b1;
   logic los_in = 1'b0, test_clk_en = 1'b0, raw_lock = 1'b0;
   logic data_out, ref_lock_cmd, lock_det, clk_src_sel;
   logic tog = 1'b0;
   int   checks = 0, failures = 0, cycles = 0;

   always #5 clk = ~clk;

   rx_source_reacq #(.SYNC_STAGES(2), .QUIET_CYCLES(QUIET), .LOCK_CYCLES(LOCK)) dut (
      .clk(clk), .rst_n(rst_n), .pri_bit(pri_bit), .lpbk_bit(lpbk_bit),
      .use_primary(use_primary), .los_in(los_in), .test_clk_en(test_clk_en),
      .raw_lock(raw_lock), .data_out(data_out), .ref_lock_cmd(ref_lock_cmd),
      .lock_det(lock_det), .clk_src_sel(clk_src_sel)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (tog) begin
            pri_bit  = ~pri_bit;
            lpbk_bit = ~lpbk_bit;
         end
      end
   endtask

   task automatic t_reset_start;
      cyc(3);
      chk("R5", "ref_lock_cmd in reset", ref_lock_cmd, 1'b1);
      chk("R5", "lock_det in reset", lock_det, 1'b0);
      chk("R5", "data_out in reset", data_out, 1'b0);
      chk("R5", "clk_src_sel in reset", clk_src_sel, 1'b0);
      rst_n = 1'b1;
      tog = 1'b1;
      cyc(5);
      chk("R7", "no release without lock", ref_lock_cmd, 1'b1);
   endtask

   task automatic t_release;
      raw_lock = 1'b1;
      cyc(LOCK - 1);
      chk("R7", "still on reference one edge early", ref_lock_cmd, 1'b1);
      cyc(1);
      chk("R7", "released after lock window", ref_lock_cmd, 1'b0);
      chk("R8", "lock_det when tracking", lock_det, 1'b1);
   endtask

   task automatic t_mux;
      tog = 1'b0;
      pri_bit = 1'b1; lpbk_bit = 1'b0;
      cyc(1);
      chk("R1", "primary bit 1", data_out, 1'b1);
      pri_bit = 1'b0; lpbk_bit = 1'b1;
      cyc(1);
      chk("R1", "primary bit 0", data_out, 1'b0);
      use_primary = 1'b0;
      cyc(2);
      chk("R1", "select not yet through sync", data_out, 1'b0);
      cyc(1);
      chk("R1", "loopback bit 1", data_out, 1'b1);
      lpbk_bit = 1'b0;
      cyc(1);
      chk("R1", "loopback bit 0", data_out, 1'b0);
      use_primary = 1'b1;
      tog = 1'b1;
      cyc(4);
   endtask

   task automatic t_track_drop;
      raw_lock = 1'b0;
      cyc(1);
      chk("R8", "lock_det follows raw_lock low", lock_det, 1'b0);
      chk("R8", "no reference on lock drop", ref_lock_cmd, 1'b0);
      raw_lock = 1'b1;
      cyc(1);
      chk("R8", "lock_det follows raw_lock high", lock_det, 1'b1);
   endtask

   task automatic t_quiet;
      tog = 1'b0;
      cyc(1);
      pri_bit = ~pri_bit;
      cyc(QUIET + 1);
      chk("R6", "tracking until idle window passes", ref_lock_cmd, 1'b0);
      cyc(1);
      chk("R6", "reference after idle line", ref_lock_cmd, 1'b1);
      chk("R6", "lock_det low on reference", lock_det, 1'b0);
      tog = 1'b1;
      cyc(LOCK + 3);
      chk("R6", "transitions clear idle and relock", ref_lock_cmd, 1'b0);
   endtask

   task automatic t_los;
      tog = 1'b0;
      pri_bit = 1'b1;
      cyc(1);
      los_in = 1'b1;
      cyc(2);
      chk("R3", "lock_det forced low", lock_det, 1'b0);
      cyc(1);
      chk("R2", "primary data forced to 0", data_out, 1'b0);
      chk("R4", "reference on loss", ref_lock_cmd, 1'b1);
      los_in = 1'b0;
      tog = 1'b1;
      cyc(LOCK + 6);
      chk("R4", "tracking after loss clears", ref_lock_cmd, 1'b0);
   endtask

   task automatic t_los_loopback;
      tog = 1'b0;
      use_primary = 1'b0;
      lpbk_bit = 1'b1;
      cyc(3);
      chk("R10", "loopback bit before loss", data_out, 1'b1);
      los_in = 1'b1;
      cyc(3);
      chk("R10", "loopback bit kept under loss", data_out, 1'b1);
      chk("R4", "reference on loss in loopback", ref_lock_cmd, 1'b1);
      los_in = 1'b0;
      use_primary = 1'b1;
      tog = 1'b1;
      cyc(LOCK + 8);
   endtask

   task automatic t_restart;
      los_in = 1'b1;
      cyc(3);
      raw_lock = 1'b0;
      los_in = 1'b0;
      cyc(4);
      chk("R7", "reference held with lock low", ref_lock_cmd, 1'b1);
      raw_lock = 1'b1;
      cyc(LOCK - 1);
      chk("R7", "not released before window", ref_lock_cmd, 1'b1);
      raw_lock = 1'b0;
      cyc(1);
      raw_lock = 1'b1;
      cyc(LOCK - 1);
      chk("R7", "count restarted after drop", ref_lock_cmd, 1'b1);
      cyc(1);
      chk("R7", "released after full window", ref_lock_cmd, 1'b0);
   endtask

   task automatic t_testclk;
      test_clk_en = 1'b1;
      cyc(1);
      chk("R9", "clk_src_sel after one edge", clk_src_sel, 1'b0);
      cyc(1);
      chk("R9", "clk_src_sel after two edges", clk_src_sel, 1'b1);
      test_clk_en = 1'b0;
      cyc(2);
      chk("R9", "clk_src_sel back to oscillator", clk_src_sel, 1'b0);
   endtask

   task automatic t_reset_mid;
      rst_n = 1'b0;
      #1;
      chk("R5", "async reset forces reference", ref_lock_cmd, 1'b1);
      chk("R5", "async reset clears lock_det", lock_det, 1'b0);
      chk("R5", "async reset clears data", data_out, 1'b0);
      cyc(2);
      rst_n = 1'b1;
      cyc(2);
   endtask

   initial begin
      t_reset_start();
      t_release();
      t_mux();
      t_track_drop();
      t_quiet();
      t_los();
      t_los_loopback();
      t_restart();
      t_testclk();
      t_reset_mid();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule